// File: doc/BRIEF.md
# Receiver Mute and Wakeup Controller

This block decides, cycle by cycle, whether a serial receiver is muted. While muted, the characters and idle events the receiver reports are not passed on, so no receive status flag is set and no receive interrupt can follow. Software sets or clears the mute state through a write strobe. Hardware leaves mute by itself when it sees the selected wakeup sequence.

A mode input selects the wakeup sequence. In idle mode, a full idle frame ends mute. This works only once at least one character has been delivered since reset. In address mode, a character whose most significant bit is 1 is an address. If its low bits equal the programmed node address, mute ends and that character is delivered. Any other address character mutes the receiver, and it is not delivered.

The receiver feeds in frame-done pulses with the received word, idle-detected pulses and the current state of its data-ready flag. The block returns the mute state and two permit pulses. Each pulse tells the receiver that the current character or idle event may set its flags.

Top module: `rx_mute_ctrl`

## Requirements
- R1: After reset, mute is 0, deliver_char is 0 and deliver_idle is 0, and no character counts as delivered.
- R2: When sw_wr is 1, the write is not locked (R3) and no hardware event (R10) occurs, mute takes the value of sw_mute on the next cycle.
- R3: With wake_sel=1 (address mode), a write while rxne_in=1 is ignored and mute keeps its value. With wake_sel=0 (idle mode), rxne_in has no effect on writes.
- R4: While mute=1, a frame_done in idle mode, or a frame_done carrying frame_word[7]=0 in address mode, gives deliver_char=0 in that cycle and leaves mute at 1. While mute=1, idle_det gives deliver_idle=0.
- R5: While mute=1 and wake_sel=0, idle_det clears mute on the next cycle, provided at least one character was delivered (deliver_char=1) since reset. deliver_idle stays 0 in that cycle.
- R6: While mute=1 and wake_sel=0, if no character has been delivered since reset, idle_det leaves mute at 1.
- R7: With wake_sel=1, a frame_done with frame_word[7]=1 and frame_word[3:0]=node_addr gives deliver_char=1 in the same cycle and mute=0 on the next cycle, whatever mute was before.
- R8: With wake_sel=1, a frame_done with frame_word[7]=1 and frame_word[3:0]!=node_addr gives deliver_char=0 and mute=1 on the next cycle, whatever mute was before.
- R9: While mute=0, a frame_done gives deliver_char=1 in the same cycle, except for the case in R8. An idle_det gives deliver_idle=1 in the same cycle.
- R10: A hardware wakeup (R5, R7) or a hardware mute (R8) in the same cycle as a software write takes precedence over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_sel | input | 1 | Wakeup method: 0 idle line, 1 address mark |
| node_addr | input | 4 | Node address matched in address mode |
| sw_wr | input | 1 | Software write strobe for the mute state |
| sw_mute | input | 1 | Value written: 1 mute, 0 active |
| rxne_in | input | 1 | Receiver data-ready flag, currently set |
| frame_done | input | 1 | Pulse: a character has been received |
| frame_word | input | 8 | Received character, bit 7 is the address mark |
| idle_det | input | 1 | Pulse: a full idle frame was detected |
| mute | output | 1 | Current mute state |
| deliver_char | output | 1 | Permit for the current character to set flags |
| deliver_idle | output | 1 | Permit for the current idle event to set flags |

## Verification
The permit outputs deliver_char and deliver_idle are combinational. They are due in the same cycle as frame_done or idle_det, and they depend on the mute value registered before that edge. Mute changes exactly one cycle after the write or wakeup event that changes it. The bench drives each stimulus on the falling edge and samples all three outputs shortly afterwards. It updates its behavioural model at the following rising edge, so a new mute value is compared on the next step. Each step of the sequence carries the tag of the requirement that step exercises. Between them, the steps cover the lock rule, the idle-wakeup precondition and same-cycle conflicts between hardware and software.

// File: rtl/rx_mute_pkg.sv
package rx_mute_pkg;

    typedef enum logic {
        WAKE_IDLE = 1'b0,
        WAKE_ADDR = 1'b1
    } wake_mode_e;

    typedef struct packed {
        logic force_mute;
        logic force_wake;
    } hw_event_t;

    function automatic logic write_locked(input wake_mode_e mode, input logic rxne);
        return (mode == WAKE_ADDR) && rxne;
    endfunction

endpackage

// File: rtl/mute_addr_match.sv
module mute_addr_match #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic [DATA_W-1:0] word,
    input  logic [ADDR_W-1:0] node,
    output logic              is_addr,
    output logic              hit
);
    localparam int MARK_BIT = DATA_W - 1;

    logic [ADDR_W-1:0] bit_eq;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_cmp
        assign bit_eq[i] = ~(word[i] ^ node[i]);
    end

    assign is_addr = word[MARK_BIT];
    assign hit     = is_addr & (&bit_eq);

endmodule

// File: rtl/mute_event_decode.sv
module mute_event_decode
    import rx_mute_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wake_mode_e mode,
    input  logic       muted,
    input  logic       seen_char,
    input  logic       frame_done,
    input  logic       idle_det,
    input  logic       is_addr,
    input  logic       hit,
    output hw_event_t  ev,
    output logic       deliver_char,
    output logic       deliver_idle
);
    logic addr_frame;
    logic idle_wake;

    assign addr_frame = (mode == WAKE_ADDR) && frame_done && is_addr;
    assign idle_wake  = (mode == WAKE_IDLE) && muted && idle_det && seen_char;

    always_comb begin
        ev.force_mute = addr_frame && !hit;
        ev.force_wake = (addr_frame && hit) || idle_wake;
    end

    always_comb begin
        deliver_char = 1'b0;
        if (frame_done) begin
            if (mode == WAKE_ADDR && is_addr)
                deliver_char = hit;
            else
                deliver_char = !muted;
        end
    end

    assign deliver_idle = idle_det && !muted;

    assert_muted_silent_R4: assert property (@(posedge clk) disable iff (rst)
        (muted && (mode == WAKE_IDLE)) |-> !deliver_char);

    assert_idle_hidden_R5: assert property (@(posedge clk) disable iff (rst)
        muted |-> !deliver_idle);

    assert_event_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(ev.force_mute && ev.force_wake));

endmodule

// File: rtl/mute_state.sv
module mute_state
    import rx_mute_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wake_mode_e mode,
    input  logic       rxne_in,
    input  logic       sw_wr,
    input  logic       sw_mute,
    input  hw_event_t  ev,
    input  logic       char_taken,
    output logic       muted,
    output logic       seen_char
);
    logic locked;

    assign locked = write_locked(mode, rxne_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            muted <= 1'b0;
        end else if (ev.force_wake) begin
            muted <= 1'b0;
        end else if (ev.force_mute) begin
            muted <= 1'b1;
        end else if (sw_wr && !locked) begin
            muted <= sw_mute;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            seen_char <= 1'b0;
        else if (char_taken)
            seen_char <= 1'b1;
    end

    assert_lock_R3: assert property (@(posedge clk) disable iff (rst)
        (sw_wr && (mode == WAKE_ADDR) && rxne_in && !ev.force_wake && !ev.force_mute)
        |=> $stable(muted));

    assert_wake_wins_R10: assert property (@(posedge clk) disable iff (rst)
        ev.force_wake |=> !muted);

endmodule

// File: rtl/rx_mute_ctrl.sv
module rx_mute_ctrl
    import rx_mute_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wake_sel,
    input  logic [ADDR_W-1:0] node_addr,
    input  logic              sw_wr,
    input  logic              sw_mute,
    input  logic              rxne_in,
    input  logic              frame_done,
    input  logic [DATA_W-1:0] frame_word,
    input  logic              idle_det,
    output logic              mute,
    output logic              deliver_char,
    output logic              deliver_idle
);
    localparam int MARK_BIT = DATA_W - 1;

    wake_mode_e mode;
    hw_event_t  ev;
    logic       is_addr;
    logic       hit;
    logic       seen_char;

    assign mode = wake_mode_e'(wake_sel);

    mute_addr_match #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_match (
        .word    (frame_word),
        .node    (node_addr),
        .is_addr (is_addr),
        .hit     (hit)
    );

    mute_event_decode u_decode (
        .clk          (clk),
        .rst          (rst),
        .mode         (mode),
        .muted        (mute),
        .seen_char    (seen_char),
        .frame_done   (frame_done),
        .idle_det     (idle_det),
        .is_addr      (is_addr),
        .hit          (hit),
        .ev           (ev),
        .deliver_char (deliver_char),
        .deliver_idle (deliver_idle)
    );

    mute_state u_state (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .rxne_in    (rxne_in),
        .sw_wr      (sw_wr),
        .sw_mute    (sw_mute),
        .ev         (ev),
        .char_taken (deliver_char),
        .muted      (mute),
        .seen_char  (seen_char)
    );

    assert_addr_miss_R8: assert property (@(posedge clk) disable iff (rst)
        (wake_sel && frame_done && frame_word[MARK_BIT]
         && (frame_word[ADDR_W-1:0] != node_addr)) |=> mute);

    assert_addr_hit_R7: assert property (@(posedge clk) disable iff (rst)
        (wake_sel && frame_done && frame_word[MARK_BIT]
         && (frame_word[ADDR_W-1:0] == node_addr)) |=> !mute);

    assert_idle_wake_R5: assert property (@(posedge clk) disable iff (rst)
        (!wake_sel && mute && idle_det && seen_char) |=> !mute);

endmodule

// File: tb/tb_rx_mute_ctrl.sv
module tb_rx_mute_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic       wake_sel;
    logic [3:0] node_addr;
    logic       sw_wr;
    logic       sw_mute;
    logic       rxne_in;
    logic       frame_done;
    logic [7:0] frame_word;
    logic       idle_det;
    logic       mute;
    logic       deliver_char;
    logic       deliver_idle;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 0;

    bit  m_mute = 0;
    bit  m_seen = 0;

    always #5 clk = ~clk;

    rx_mute_ctrl dut (
        .clk(clk), .rst(rst), .wake_sel(wake_sel), .node_addr(node_addr),
        .sw_wr(sw_wr), .sw_mute(sw_mute), .rxne_in(rxne_in),
        .frame_done(frame_done), .frame_word(frame_word), .idle_det(idle_det),
        .mute(mute), .deliver_char(deliver_char), .deliver_idle(deliver_idle)
    );

    task automatic cmp(input string tag, input string what, input bit act, input bit exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input string tag, input bit w, input bit wv, input bit rx,
                        input bit fd, input logic [7:0] wd, input bit idl);
        bit is_mark, match, e_ch, e_idl;
        sw_wr = w; sw_mute = wv; rxne_in = rx;
        frame_done = fd; frame_word = wd; idle_det = idl;
        #1;
        is_mark = wd[7];
        match   = is_mark && (wd[3:0] == node_addr);
        if (!fd)
            e_ch = 0;
        else if (wake_sel && is_mark)
            e_ch = match;
        else
            e_ch = !m_mute;
        e_idl = idl && !m_mute;
        cmp(tag, "mute", mute, m_mute);
        cmp(tag, "deliver_char", deliver_char, e_ch);
        cmp(tag, "deliver_idle", deliver_idle, e_idl);
        @(posedge clk);
        if (wake_sel && fd && is_mark)
            m_mute = !match;
        else if (!wake_sel && idl && m_mute && m_seen)
            m_mute = 0;
        else if (w && !(wake_sel && rx))
            m_mute = wv;
        if (e_ch) m_seen = 1;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; wake_sel = 0; node_addr = 4'h5;
        sw_wr = 0; sw_mute = 0; rxne_in = 0; frame_done = 0; frame_word = 0; idle_det = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        step("R1", 0, 0, 0, 0, 8'h00, 0);
        step("R1", 0, 0, 0, 0, 8'h00, 0);
        // idle mode, no character seen yet
        step("R2", 1, 1, 0, 0, 8'h00, 0);
        step("R6", 0, 0, 0, 0, 8'h00, 1);
        step("R4", 0, 0, 0, 1, 8'h41, 0);
        step("R6", 0, 0, 0, 0, 8'h00, 1);
        step("R2", 1, 0, 0, 0, 8'h00, 0);
        step("R9", 0, 0, 0, 1, 8'h33, 0);
        step("R9", 0, 0, 0, 0, 8'h00, 1);
        step("R2", 1, 1, 0, 0, 8'h00, 0);
        step("R4", 0, 0, 0, 1, 8'h85, 0);
        step("R5", 0, 0, 0, 0, 8'h00, 1);
        step("R5", 0, 0, 0, 0, 8'h00, 0);
        // idle mode ignores rxne for writes
        step("R3", 1, 1, 1, 0, 8'h00, 0);
        step("R10", 1, 1, 0, 0, 8'h00, 1);
        step("R10", 0, 0, 0, 0, 8'h00, 0);
        step("R2", 1, 1, 0, 0, 8'h00, 0);
        // address mode
        wake_sel = 1;
        step("R3", 1, 0, 1, 0, 8'h00, 0);
        step("R3", 0, 0, 1, 0, 8'h00, 0);
        step("R4", 0, 0, 0, 1, 8'h15, 0);
        step("R4", 0, 0, 0, 0, 8'h00, 1);
        step("R8", 0, 0, 0, 1, 8'h83, 0);
        step("R7", 0, 0, 0, 1, 8'h85, 0);
        step("R9", 0, 0, 0, 1, 8'h12, 0);
        step("R9", 0, 0, 0, 0, 8'h00, 1);
        step("R8", 0, 0, 0, 1, 8'h89, 0);
        step("R7", 0, 0, 0, 1, 8'h95, 0);
        step("R9", 0, 0, 0, 1, 8'h85, 0);
        step("R10", 1, 0, 0, 1, 8'h8A, 0);
        step("R10", 1, 1, 0, 1, 8'hF5, 0);
        step("R3", 1, 1, 1, 0, 8'h00, 0);
        step("R2", 1, 1, 0, 0, 8'h00, 0);
        node_addr = 4'hC;
        step("R8", 0, 0, 0, 1, 8'h85, 0);
        step("R7", 0, 0, 0, 1, 8'h8C, 0);
        step("R2", 0, 0, 0, 0, 8'h00, 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule